// File: doc/BRIEF.md
# PLL Bring-up and Clock-Gate Sequencer

This block controls a frequency-synthesis PLL that lives outside it. It decides when the PLL is powered down, when the raw reference clock bypasses the PLL, and when the synthesized clock may reach the rest of the chip. Software reaches it through a simple write-strobe register port. One register selects the mode. A second holds direct control bits for manual operation. Three more hold the M, N and P divider values that go to the PLL. The PLL lock indication arrives on an input pin. The block synchronizes it and reports it back.

In automatic mode the block runs the bring-up on its own. It first drops bypass and the clock gate. It then hands the divider values to the PLL and releases power-down. It waits a worst-case lock time measured in reference-clock cycles, then opens the clock gate. This happens once after reset, again on every divider write, and again whenever software moves from manual to automatic mode. In manual mode the three control outputs simply mirror software bits and the sequencer stays out of the way. If the lock input is still low when the wait ends, the gate opens anyway and a sticky flag records the miss.

Top module: `clkpll_sequencer`

## Requirements
- R1: While reset is asserted and just after it, pllPd, pllBypass and clkEnable are all 1, lockStatus and lockMiss are 0, and divM, divN and divP are 0. The mode is automatic.
- R2: In automatic mode, the cycle after a triggering clock edge shows pllPd=1, pllBypass=0 and clkEnable=0 for two cycles. Then pllPd=0 and clkEnable=0 hold for exactly W cycles, with W = ceil(REF_KHZ*WAIT_US/1000). After that, clkEnable=1 with pllPd=0 and pllBypass=0, and this state holds. The first rising edge after reset release is such a trigger.
- R3: In automatic mode, a write to 0x3A (M), 0x3B (N) or 0x3C (P) restarts the sequence of R2 from its first step. This holds at any point, including during the wait. The new divider value appears on its output two cycles after the write edge.
- R4: With bit 5 of register 0x38 at 0, the mode is manual. pllPd, pllBypass and clkEnable then equal bits 0, 1 and 2 of register 0x39 (reset value 1 each) from the cycle after the write. Divider outputs follow their registers one cycle late. Divider writes start no sequence, and lockMiss does not change.
- R5: Only bit 5 of register 0x38 has any effect. Its other bits are ignored.
- R6: A write that changes the mode from manual to automatic starts one full R2 sequence. Writing bit 5 = 1 while already in automatic mode leaves the outputs untouched.
- R7: lockStatus equals lockIn delayed through SYNC_STAGES (default 2) reference-clock flops.
- R8: If the synchronized lock is 0 in the last wait cycle, lockMiss becomes 1 in the same cycle that clkEnable rises. The gate still opens. lockMiss holds until the edge of the next sequence trigger, which clears it.
- R9: Writes to any address other than 0x38 to 0x3C have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| lockIn | input | 1 | Raw lock indication from the PLL |
| pllPd | output | 1 | PLL power-down |
| pllBypass | output | 1 | Route reference clock around the PLL |
| clkEnable | output | 1 | Clock gate enable toward the chip |
| lockStatus | output | 1 | Synchronized lock indication |
| lockMiss | output | 1 | Sticky: lock was absent when the wait ended |
| divM | output | M_W | Divider M applied to the PLL |
| divN | output | N_W | Divider N applied to the PLL |
| divP | output | P_W | Divider P applied to the PLL |

## Verification
A wrong sequencer state shows up on the pllPd/pllBypass/clkEnable triple in the very next cycle, because these outputs decode the state register directly. For that reason the bench compares the triple on every cycle of each sequence. A wait counter that is off by one moves the rising edge of clkEnable by one cycle, and a dropped restart leaves the gate open after a divider write. A bad latch of the divider value shows up two cycles after the write. A mis-set miss flag is visible in the cycle where the gate opens.

// File: rtl/clkpll_pkg.sv
package clkpll_pkg;

  localparam logic [7:0] ADDR_MODE = 8'h38;
  localparam logic [7:0] ADDR_MAN  = 8'h39;
  localparam logic [7:0] ADDR_M    = 8'h3A;
  localparam logic [7:0] ADDR_N    = 8'h3B;
  localparam logic [7:0] ADDR_P    = 8'h3C;
  localparam int AUTO_BIT = 5;

  typedef enum logic [2:0] {
    SEQ_BOOT, SEQ_MAN, SEQ_DIS, SEQ_LOAD, SEQ_WAIT, SEQ_RUN
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic loadDiv;
    logic cntEn;
    logic setMiss;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic autoNext;
    logic restart;
    logic timerDone;
    logic lockSync;
    logic swPd;
    logic swByp;
    logic swClkEn;
  } dpStatus_t;

endpackage

// File: rtl/clkpll_dp.sv
module clkpll_dp
  import clkpll_pkg::*;
#(
  parameter int M_W = 8,
  parameter int N_W = 6,
  parameter int P_W = 3,
  parameter int WAIT_CYC = 13500,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [7:0]     wrAddr,
  input  logic [7:0]     wrData,
  input  logic           lockIn,
  input  ctlStrobe_t     strobe,
  output dpStatus_t      st,
  output logic           autoMode,
  output logic           lockStatus,
  output logic           lockMiss,
  output logic [M_W-1:0] divM,
  output logic [N_W-1:0] divN,
  output logic [P_W-1:0] divP
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic hitMode, hitMan, hitM, hitN, hitP, hitDiv;
  logic autoQ;
  logic [2:0] swQ;
  logic [M_W-1:0] regM;
  logic [N_W-1:0] regN;
  logic [P_W-1:0] regP;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0] cnt;

  assign hitMode = wrEn && (wrAddr == ADDR_MODE);
  assign hitMan  = wrEn && (wrAddr == ADDR_MAN);
  assign hitM    = wrEn && (wrAddr == ADDR_M);
  assign hitN    = wrEn && (wrAddr == ADDR_N);
  assign hitP    = wrEn && (wrAddr == ADDR_P);
  assign hitDiv  = hitM || hitN || hitP;

  assign st.autoNext  = hitMode ? wrData[AUTO_BIT] : autoQ;
  assign st.restart   = (hitDiv && st.autoNext) || (hitMode && wrData[AUTO_BIT] && !autoQ);
  assign st.timerDone = (cnt == CNT_W'(WAIT_CYC - 1));
  assign st.lockSync  = syncQ[SYNC_STAGES-1];
  assign st.swPd      = swQ[0];
  assign st.swByp     = swQ[1];
  assign st.swClkEn   = swQ[2];

  assign autoMode   = autoQ;
  assign lockStatus = syncQ[SYNC_STAGES-1];

  // software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoQ <= 1'b1;
      swQ   <= 3'b111;
      regM  <= '0;
      regN  <= '0;
      regP  <= '0;
    end else begin
      if (hitMode) autoQ <= wrData[AUTO_BIT];
      if (hitMan)  swQ   <= wrData[2:0];
      if (hitM)    regM  <= wrData[M_W-1:0];
      if (hitN)    regN  <= wrData[N_W-1:0];
      if (hitP)    regP  <= wrData[P_W-1:0];
    end
  end

  // dividers handed to the PLL
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM <= '0;
      divN <= '0;
      divP <= '0;
    end else if (strobe.loadDiv) begin
      divM <= regM;
      divN <= regN;
      divP <= regP;
    end
  end

  // lock synchronizer, lock-wait timer, miss flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      cnt      <= '0;
      lockMiss <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], lockIn};
      cnt   <= strobe.cntEn ? cnt + 1'b1 : '0;
      if (st.restart)        lockMiss <= 1'b0;
      else if (strobe.setMiss) lockMiss <= 1'b1;
    end
  end

endmodule

// File: rtl/clkpll_ctrl.sv
module clkpll_ctrl
  import clkpll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  output ctlStrobe_t strobe,
  output logic       pllPd,
  output logic       pllBypass,
  output logic       clkEnable
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_BOOT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    if (!st.autoNext)    stateNext = SEQ_MAN;
    else if (st.restart) stateNext = SEQ_DIS;
    else begin
      unique case (state)
        SEQ_BOOT, SEQ_MAN: stateNext = SEQ_DIS;
        SEQ_DIS:           stateNext = SEQ_LOAD;
        SEQ_LOAD:          stateNext = SEQ_WAIT;
        SEQ_WAIT:          stateNext = st.timerDone ? SEQ_RUN : SEQ_WAIT;
        SEQ_RUN:           stateNext = SEQ_RUN;
        default:           stateNext = SEQ_DIS;
      endcase
    end
  end

  always_comb begin
    strobe.loadDiv = (state == SEQ_LOAD) || (state == SEQ_MAN);
    strobe.cntEn   = (state == SEQ_WAIT);
    strobe.setMiss = (state == SEQ_WAIT) && st.timerDone && !st.lockSync
                     && (stateNext == SEQ_RUN);
    unique case (state)
      SEQ_MAN:           {pllPd, pllBypass, clkEnable} = {st.swPd, st.swByp, st.swClkEn};
      SEQ_DIS, SEQ_LOAD: {pllPd, pllBypass, clkEnable} = 3'b100;
      SEQ_WAIT:          {pllPd, pllBypass, clkEnable} = 3'b000;
      SEQ_RUN:           {pllPd, pllBypass, clkEnable} = 3'b001;
      default:           {pllPd, pllBypass, clkEnable} = 3'b111;
    endcase
  end

endmodule

// File: rtl/clkpll_sequencer.sv
module clkpll_sequencer
  import clkpll_pkg::*;
#(
  parameter int REF_KHZ = 27000,
  parameter int WAIT_US = 500,
  parameter int M_W = 8,
  parameter int N_W = 6,
  parameter int P_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [7:0]     wrAddr,
  input  logic [7:0]     wrData,
  input  logic           lockIn,
  output logic           pllPd,
  output logic           pllBypass,
  output logic           clkEnable,
  output logic           lockStatus,
  output logic           lockMiss,
  output logic [M_W-1:0] divM,
  output logic [N_W-1:0] divN,
  output logic [P_W-1:0] divP
);
  localparam int WAIT_CYC = (REF_KHZ * WAIT_US + 999) / 1000;

  ctlStrobe_t strobe;
  dpStatus_t  dpSt;
  logic        autoModeW;
  logic        restartW;
  logic [31:0] waitCycW;

  assign restartW = dpSt.restart;
  assign waitCycW = 32'(WAIT_CYC);

  clkpll_dp #(
    .M_W(M_W), .N_W(N_W), .P_W(P_W),
    .WAIT_CYC(WAIT_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lockIn(lockIn), .strobe(strobe), .st(dpSt), .autoMode(autoModeW),
    .lockStatus(lockStatus), .lockMiss(lockMiss),
    .divM(divM), .divN(divN), .divP(divP)
  );

  clkpll_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .st(dpSt), .strobe(strobe),
    .pllPd(pllPd), .pllBypass(pllBypass), .clkEnable(clkEnable)
  );

endmodule

// File: rtl/clkpll_sequencer_chk.sv
module clkpll_sequencer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        pllPd,
  input logic        pllBypass,
  input logic        clkEnable,
  input logic        lockMiss,
  input logic        autoMode,
  input logic        restart,
  input logic [31:0] waitCyc
);
  logic [31:0] offCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   offCnt <= '0;
    else if (pllPd || clkEnable) offCnt <= '0;
    else                         offCnt <= offCnt + 1;
  end

  // R2: the gate opens only after exactly the full lock wait
  p_wait_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    autoMode && $rose(clkEnable) |-> offCnt == waitCyc);

  // R2: the gate opens only with the PLL powered and in use
  p_gate_powered_r2: assert property (@(posedge clk) disable iff (!rstN)
    autoMode && $rose(clkEnable) |-> !pllPd && !pllBypass);

  // R2: power-down is released only after bypass and gate have dropped
  p_release_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    autoMode && $fell(pllPd) |-> !pllBypass && !clkEnable && $past(!pllBypass && !clkEnable));

  // R8: miss flag is sticky until a restart
  p_miss_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockMiss && !restart |=> lockMiss);

  // R4: manual mode never touches the miss flag
  p_manual_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !autoMode && !restart |=> $stable(lockMiss));

endmodule

bind clkpll_sequencer clkpll_sequencer_chk u_chk (
  .clk(clk), .rstN(rstN), .pllPd(pllPd), .pllBypass(pllBypass),
  .clkEnable(clkEnable), .lockMiss(lockMiss), .autoMode(autoModeW),
  .restart(restartW), .waitCyc(waitCycW)
);

// File: tb/sim_clkpll_sequencer.sv
`timescale 1ns/1ps
module sim_clkpll_sequencer;
  localparam int REF_KHZ = 20;
  localparam int WAIT_US = 500;
  localparam int W = (REF_KHZ * WAIT_US + 999) / 1000;  // 10 cycles

  logic clk = 1'b0;
  logic rstN, wrEn, lockIn;
  logic [7:0] wrAddr, wrData;
  logic pllPd, pllBypass, clkEnable, lockStatus, lockMiss;
  logic [7:0] divM;
  logic [5:0] divN;
  logic [2:0] divP;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int mAct = 0, nAct = 0, pAct = 0;

  always #4 clk = ~clk;  // 125 MHz

  clkpll_sequencer #(.REF_KHZ(REF_KHZ), .WAIT_US(WAIT_US)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lockIn(lockIn), .pllPd(pllPd), .pllBypass(pllBypass), .clkEnable(clkEnable),
    .lockStatus(lockStatus), .lockMiss(lockMiss),
    .divM(divM), .divN(divN), .divP(divP)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int divs(input int m, input int n, input int p);
    return (m << 9) | (n << 3) | p;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = 8'h00; wrData = 8'h00;
  endtask

  // Called at the first sample point after a trigger edge.
  task automatic seq(input string req, input int m, input int n, input int p, input bit expMiss);
    for (int i = 0; i < W + 4; i++) begin
      int e3;
      e3 = (i < 2) ? 3'b100 : (i < W + 2) ? 3'b000 : 3'b001;
      chk(req, $sformatf("pd/byp/en at step %0d", i), {pllPd, pllBypass, clkEnable}, e3);
      chk(req, $sformatf("dividers at step %0d", i), divs(divM, divN, divP),
          (i < 2) ? divs(mAct, nAct, pAct) : divs(m, n, p));
      if (i == 0) chk(req, "miss cleared at start", lockMiss, 0);
      if (i == W + 2) chk("R8", "miss when gate opens", lockMiss, expMiss);
      @(negedge clk);
    end
    mAct = m; nAct = n; pAct = p;
  endtask

  task automatic hold(input string req, input int e3, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(req, "outputs held", {pllPd, pllBypass, clkEnable}, e3);
      chk(req, "dividers held", divs(divM, divN, divP), divs(mAct, nAct, pAct));
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = 8'h00; wrData = 8'h00; lockIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pd/byp/en in reset", {pllPd, pllBypass, clkEnable}, 3'b111);
    chk("R1", "lockStatus in reset", lockStatus, 0);
    chk("R1", "lockMiss in reset", lockMiss, 0);
    chk("R1", "dividers in reset", divs(divM, divN, divP), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 initial sequence after reset
    seq("R2", 0, 0, 0, 1'b0);
    hold("R2", 3'b001, 4);

    // R3 divider write restarts
    wr(8'h3A, 8'h55);
    seq("R3", 8'h55, nAct, pAct, 1'b0);

    // R3 restart in the middle of the wait
    wr(8'h3B, 8'h0A);
    for (int i = 0; i < 5; i++) begin
      chk("R3", "partial sequence", {pllPd, pllBypass, clkEnable}, (i < 2) ? 3'b100 : 3'b000);
      @(negedge clk);
    end
    nAct = 8'h0A;
    wr(8'h3C, 8'h05);
    seq("R3", mAct, nAct, 5, 1'b0);

    // R7 lock synchronizer latency, falling
    @(negedge clk); lockIn = 1'b0;
    @(negedge clk); chk("R7", "lockStatus after 1 edge", lockStatus, 1);
    @(negedge clk); chk("R7", "lockStatus after 2 edges", lockStatus, 0);

    // R8 wait ends without lock
    wr(8'h3A, 8'h33);
    seq("R8", 8'h33, nAct, pAct, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk("R8", "miss sticky", lockMiss, 1);
      chk("R8", "gate still open", clkEnable, 1);
      @(negedge clk);
    end

    // R7 rising, then R8 clear on restart
    lockIn = 1'b1;
    @(negedge clk); chk("R7", "lockStatus after 1 edge", lockStatus, 0);
    @(negedge clk); chk("R7", "lockStatus after 2 edges", lockStatus, 1);
    wr(8'h3B, 8'h15);
    seq("R8", mAct, 8'h15, pAct, 1'b0);

    // R6 auto rewrite does nothing; R9 unmapped writes ignored
    wr(8'h38, 8'h20);
    hold("R6", 3'b001, 3);
    wr(8'h3D, 8'hFF);
    wr(8'h37, 8'hFF);
    hold("R9", 3'b001, 3);
    chk("R9", "miss untouched", lockMiss, 0);

    // R5 reserved bits set, bit 5 clear -> manual; R4 reset value of soft bits
    wr(8'h38, 8'hDF);
    hold("R5", 3'b111, W + 4);
    wr(8'h39, 8'h00);
    chk("R4", "manual bits 000", {pllPd, pllBypass, clkEnable}, 3'b000);
    wr(8'h39, 8'hF5);
    chk("R4", "manual bits 101", {pllPd, pllBypass, clkEnable}, 3'b101);
    wr(8'h3A, 8'h12);
    chk("R4", "manual M one cycle late", divM, mAct);
    @(negedge clk);
    chk("R4", "manual M tracks", divM, 8'h12);
    mAct = 8'h12;
    hold("R4", 3'b101, W + 4);
    chk("R4", "manual miss stable", lockMiss, 0);
    wr(8'h3D, 8'hFF);
    wr(8'h30, 8'h00);
    hold("R9", 3'b101, 3);

    // R6 manual -> automatic with reserved bits set (R5)
    wr(8'h38, 8'hFF);
    seq("R6", mAct, nAct, pAct, 1'b0);
    hold("R6", 3'b001, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule